// File: doc/BRIEF.md
# Serial Port Interrupt Priority Identifier

This block is the interrupt logic of a 16550-style serial port. It watches event pulses from the receiver and the transmitter, the levels of the four modem-control inputs, and the receive FIFO fill level. It keeps one latched flag for each source that needs one. Each flag is qualified by its enable bit. The block then picks the most urgent qualified source and reports it as an 8-bit identification byte. It also drives a single interrupt request line.

Software services an interrupt by reading the identification byte and then accessing the register that belongs to the reported source. Each source has its own clearing access, which reaches the block as a one-cycle strobe. Bus decoding, the FIFOs and the status register contents live elsewhere and are seen here only as events, levels and strobes. In FIFO mode a character-timeout source is also active. It fires when the receive FIFO holds data but has been idle for a programmable number of cycles.

Top module: `uart_irq_ident`

## Requirements
- R1: After reset, with FIFO mode off and no event, `iir_byte` is 0x01 and `irq` is 0.
- R2: In `iir_byte`, bit 7 equals `fifo_mode` and bits 6:4 are 0. Bit 0 is 0 when an enabled source is pending and 1 otherwise. With nothing pending, bits 3:1 are 000, so the idle byte is 0x81 in FIFO mode and 0x01 otherwise.
- R3: Bits 3:1 name the highest-priority enabled pending source. The order is line status 011, then received data 010, then character timeout 110, then transmitter empty 001, then modem status 000. Received data is reported ahead of timeout when both are pending.
- R4: A `line_err_evt` pulse latches the line-status flag. A `rd_lsr` strobe clears it one cycle later.
- R5: With FIFO mode off, an `rx_char_evt` pulse latches the received-data flag, and a `rd_rbr` strobe clears it.
- R6: With FIFO mode on, received data is pending exactly while `rx_level` >= `rx_trig` and `rx_level` is nonzero. It is not latched, so it drops as soon as the level falls below the trigger.
- R7: With FIFO mode on and `rx_level` nonzero, suppose neither `rx_char_evt` nor `rd_rbr` occurs for `idle_limit`+1 cycles after the last of them. Code 110 then becomes pending. A `rd_rbr` strobe clears it, and it never appears with FIFO mode off.
- R8: A `tx_empty_evt` pulse latches the transmitter-empty flag. A `wr_thr` strobe clears it. A `rd_iir` strobe clears it only when the byte read in that cycle reports code 001.
- R9: Any change on any bit of `modem_in` latches the modem flag. A `rd_msr` strobe clears it.
- R10: `ien` bit 0 enables received data and timeout, bit 1 transmitter empty, bit 2 line status and bit 3 modem status. A disabled source is neither reported nor raises `irq`, but its latched flag is kept and reappears when re-enabled.
- R11: `irq` is 1 exactly when an enabled source is pending.
- R12: The byte presented during a `rd_iir` cycle is the value before that read's own clear. The clear shows from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fifo_mode | input | 1 | FIFO mode selected |
| ien | input | 4 | Source enables (see R10) |
| line_err_evt | input | 1 | Overrun, parity, framing or break detected |
| rx_char_evt | input | 1 | A character was received |
| tx_empty_evt | input | 1 | Transmit holding register became empty |
| modem_in | input | 4 | Modem-control input levels |
| rx_level | input | LVL_W | Receive FIFO fill level |
| rx_trig | input | LVL_W | Receive FIFO trigger level (nonzero) |
| idle_limit | input | CNT_W | Character-timeout idle interval in cycles |
| rd_lsr | input | 1 | Line status register read strobe |
| rd_rbr | input | 1 | Receive buffer read strobe |
| rd_msr | input | 1 | Modem status register read strobe |
| rd_iir | input | 1 | Identification byte read strobe |
| wr_thr | input | 1 | Transmit holding register write strobe |
| iir_byte | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
Every latched flag and the timeout counter surface on `iir_byte` in the same cycle they change, so a wrong internal state appears at the ports within one clock. The one exception is a flag hidden behind a higher-priority or disabled source. That error is only exposed once the sources above it are serviced or its enable is set, which is why the bench sweeps all enable combinations with every source pending and walks the priority chain down by servicing. A timeout counter off by one cycle shows as the code 110 arriving a cycle early or late.

// File: rtl/uart_irq_pkg.sv
// Shared identity codes and the pending-source vector for the interrupt identifier.
package uart_irq_pkg;

    typedef enum logic [2:0] {
        ID_MODEM = 3'b000,
        ID_TXE   = 3'b001,
        ID_RXD   = 3'b010,
        ID_LINE  = 3'b011,
        ID_TMO   = 3'b110
    } irq_id_e;

    typedef struct packed {
        logic line;
        logic rxd;
        logic tmo;
        logic txe;
        logic modem;
    } irq_vec_t;

endpackage

// File: rtl/irq_src_flags.sv
// Latched source flags for line status, non-FIFO received data,
// transmitter empty and modem change.
// Assumes event and strobe inputs are single-cycle pulses. A new event in
// the same cycle as its clearing access wins, so that event is not lost.
module irq_src_flags #(
    parameter int MODEM_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fifo_mode,
    input  logic               line_err_evt,
    input  logic               rx_char_evt,
    input  logic               tx_empty_evt,
    input  logic [MODEM_W-1:0] modem_in,
    input  logic               rd_lsr,
    input  logic               rd_rbr,
    input  logic               rd_msr,
    input  logic               wr_thr,
    input  logic               txe_ack,
    output logic               line_flag,
    output logic               rxd_flag,
    output logic               txe_flag,
    output logic               modem_flag
);

    logic [MODEM_W-1:0] modem_prev;
    logic               modem_chg;

    // Detect any edge on the modem-control inputs.
    always_comb modem_chg = |(modem_in ^ modem_prev);

    // Track the previous modem levels, seeded from the live inputs in reset.
    always_ff @(posedge clk) begin
        modem_prev <= modem_in;
    end

    // Line-status flag: set by an error event, cleared by reading line status.
    always_ff @(posedge clk) begin
        if (!rst_n)            line_flag <= 1'b0;
        else if (line_err_evt) line_flag <= 1'b1;
        else if (rd_lsr)       line_flag <= 1'b0;
    end

    // Received-data flag, used only outside FIFO mode.
    always_ff @(posedge clk) begin
        if (!rst_n || fifo_mode) rxd_flag <= 1'b0;
        else if (rx_char_evt)    rxd_flag <= 1'b1;
        else if (rd_rbr)         rxd_flag <= 1'b0;
    end

    // Transmitter-empty flag: cleared by a holding write or an acknowledged read.
    always_ff @(posedge clk) begin
        if (!rst_n)                 txe_flag <= 1'b0;
        else if (tx_empty_evt)      txe_flag <= 1'b1;
        else if (wr_thr || txe_ack) txe_flag <= 1'b0;
    end

    // Modem flag: set by any input change, cleared by reading modem status.
    always_ff @(posedge clk) begin
        if (!rst_n)         modem_flag <= 1'b0;
        else if (modem_chg) modem_flag <= 1'b1;
        else if (rd_msr)    modem_flag <= 1'b0;
    end

    assert_line_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        line_err_evt |=> line_flag);
    assert_line_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lsr && !line_err_evt) |=> !line_flag);
    assert_txe_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_thr && !tx_empty_evt) |=> !txe_flag);
    assert_modem_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_msr && !modem_chg) |=> !modem_flag);

endmodule

// File: rtl/irq_char_timer.sv
// Character-timeout detector for FIFO mode.
// The idle counter restarts on a received character, a buffer read or an
// empty FIFO. Once it has sat at idle_limit for one more cycle, the
// timeout flag is raised. Assumes idle_limit is steady while counting.
module irq_char_timer #(
    parameter int LVL_W = 5,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fifo_mode,
    input  logic [LVL_W-1:0] rx_level,
    input  logic             rx_char_evt,
    input  logic             rd_rbr,
    input  logic [CNT_W-1:0] idle_limit,
    output logic             tmo_flag
);

    logic [CNT_W-1:0] idle_cnt;
    logic             restart;
    logic             at_limit;

    // Decide when the idle interval starts over.
    always_comb begin
        restart  = rx_char_evt || rd_rbr || (rx_level == '0) || !fifo_mode;
        at_limit = (idle_cnt == idle_limit);
    end

    // Idle counter, saturating at the programmed limit.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) idle_cnt <= '0;
        else if (!at_limit)    idle_cnt <= idle_cnt + 1'b1;
    end

    // Timeout flag: held until the buffer is read or FIFO mode is left.
    always_ff @(posedge clk) begin
        if (!rst_n || !fifo_mode) tmo_flag <= 1'b0;
        else if (rd_rbr)          tmo_flag <= 1'b0;
        else if (!restart && at_limit) tmo_flag <= 1'b1;
    end

    assert_tmo_fifo_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmo_flag) |-> $past(fifo_mode));
    assert_tmo_read_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_rbr |=> !tmo_flag);

endmodule

// File: rtl/irq_prio_enc.sv
// Fixed-priority encoder. It turns the masked pending vector into the
// identification byte and the interrupt line.
// Assumes the timeout bit is already qualified by FIFO mode.
module irq_prio_enc
    import uart_irq_pkg::*;
(
    input  irq_vec_t   pend,
    input  logic       fifo_mode,
    output logic [7:0] iir_byte,
    output logic       irq
);

    irq_id_e id;
    logic    any;

    // Select the most urgent pending source.
    always_comb begin
        any = |pend;
        if (pend.line)       id = ID_LINE;
        else if (pend.rxd)   id = ID_RXD;
        else if (pend.tmo)   id = ID_TMO;
        else if (pend.txe)   id = ID_TXE;
        else                 id = ID_MODEM;
    end

    // Assemble the byte; identity is zeroed when nothing is pending.
    always_comb begin
        iir_byte = {fifo_mode, 3'b000, (any ? id : ID_MODEM), ~any};
        irq      = any;
    end

endmodule

// File: rtl/uart_irq_ident.sv
// Interrupt priority identifier of a 16550-style serial port.
// It gathers the latched and level sources, applies the enable mask and
// reports the winner. The byte is combinational from the current state, so
// a read sees the value before its own clearing edge.
// Assumes rx_trig is nonzero and all strobes last one cycle.
module uart_irq_ident
    import uart_irq_pkg::*;
#(
    parameter int LVL_W   = 5,
    parameter int CNT_W   = 8,
    parameter int MODEM_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fifo_mode,
    input  logic [3:0]         ien,
    input  logic               line_err_evt,
    input  logic               rx_char_evt,
    input  logic               tx_empty_evt,
    input  logic [MODEM_W-1:0] modem_in,
    input  logic [LVL_W-1:0]   rx_level,
    input  logic [LVL_W-1:0]   rx_trig,
    input  logic [CNT_W-1:0]   idle_limit,
    input  logic               rd_lsr,
    input  logic               rd_rbr,
    input  logic               rd_msr,
    input  logic               rd_iir,
    input  logic               wr_thr,
    output logic [7:0]         iir_byte,
    output logic               irq
);

    localparam int EN_RXD   = 0;
    localparam int EN_TXE   = 1;
    localparam int EN_LINE  = 2;
    localparam int EN_MODEM = 3;

    logic     line_flag, rxd_flag, txe_flag, modem_flag, tmo_flag;
    logic     rxd_fifo, txe_ack;
    irq_vec_t pend;

    irq_src_flags #(.MODEM_W(MODEM_W)) u_flags (
        .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode),
        .line_err_evt(line_err_evt), .rx_char_evt(rx_char_evt),
        .tx_empty_evt(tx_empty_evt), .modem_in(modem_in),
        .rd_lsr(rd_lsr), .rd_rbr(rd_rbr), .rd_msr(rd_msr),
        .wr_thr(wr_thr), .txe_ack(txe_ack),
        .line_flag(line_flag), .rxd_flag(rxd_flag),
        .txe_flag(txe_flag), .modem_flag(modem_flag)
    );

    irq_char_timer #(.LVL_W(LVL_W), .CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode),
        .rx_level(rx_level), .rx_char_evt(rx_char_evt),
        .rd_rbr(rd_rbr), .idle_limit(idle_limit), .tmo_flag(tmo_flag)
    );

    // Received-data level source for FIFO mode.
    always_comb rxd_fifo = (rx_level >= rx_trig) && (rx_level != '0);

    // Apply enables to every source.
    always_comb begin
        pend.line  = line_flag  && ien[EN_LINE];
        pend.rxd   = (fifo_mode ? rxd_fifo : rxd_flag) && ien[EN_RXD];
        pend.tmo   = tmo_flag   && fifo_mode && ien[EN_RXD];
        pend.txe   = txe_flag   && ien[EN_TXE];
        pend.modem = modem_flag && ien[EN_MODEM];
    end

    irq_prio_enc u_enc (
        .pend(pend), .fifo_mode(fifo_mode),
        .iir_byte(iir_byte), .irq(irq)
    );

    // An identification read acknowledges transmitter empty only if it is shown.
    always_comb txe_ack = rd_iir && !iir_byte[0] && (iir_byte[3:1] == ID_TXE);

    assert_no_tmo_code_nonfifo_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !fifo_mode |-> (iir_byte[7:3] == 5'b0));
    assert_read_snapshot_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_iir && !iir_byte[0] && iir_byte[3:1] == 3'b001 && !tx_empty_evt)
            |=> !txe_flag);

endmodule

// File: tb/uart_irq_ident_test.sv
module uart_irq_ident_test;

    localparam int LVL_W = 5;
    localparam int CNT_W = 8;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             fifo_mode = 1'b0;
    logic [3:0]       ien = 4'h0;
    logic             line_err_evt = 1'b0, rx_char_evt = 1'b0, tx_empty_evt = 1'b0;
    logic [3:0]       modem_in = 4'h0;
    logic [LVL_W-1:0] rx_level = '0;
    logic [LVL_W-1:0] rx_trig = 5'd4;
    logic [CNT_W-1:0] idle_limit = 8'd200;
    logic             rd_lsr = 1'b0, rd_rbr = 1'b0, rd_msr = 1'b0, rd_iir = 1'b0, wr_thr = 1'b0;
    logic [7:0]       iir_byte;
    logic             irq;

    int total = 0;
    int bad   = 0;

    always #5 clk = ~clk;

    uart_irq_ident #(.LVL_W(LVL_W), .CNT_W(CNT_W), .MODEM_W(4)) uut (
        .clk(clk), .rst_n(rst_n), .fifo_mode(fifo_mode), .ien(ien),
        .line_err_evt(line_err_evt), .rx_char_evt(rx_char_evt),
        .tx_empty_evt(tx_empty_evt), .modem_in(modem_in),
        .rx_level(rx_level), .rx_trig(rx_trig), .idle_limit(idle_limit),
        .rd_lsr(rd_lsr), .rd_rbr(rd_rbr), .rd_msr(rd_msr),
        .rd_iir(rd_iir), .wr_thr(wr_thr),
        .iir_byte(iir_byte), .irq(irq)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    // One-cycle strobe: 0 line,1 rxchar,2 txempty,3 lsr,4 rbr,5 msr,6 iir,7 thr
    task automatic strobe(input int which);
        case (which)
            0: line_err_evt = 1'b1;
            1: rx_char_evt  = 1'b1;
            2: tx_empty_evt = 1'b1;
            3: rd_lsr       = 1'b1;
            4: rd_rbr       = 1'b1;
            5: rd_msr       = 1'b1;
            6: rd_iir       = 1'b1;
            default: wr_thr = 1'b1;
        endcase
        step();
        {line_err_evt, rx_char_evt, tx_empty_evt, rd_lsr, rd_rbr, rd_msr, rd_iir, wr_thr} = '0;
    endtask

    // Expected byte from the priority rules.
    function automatic logic [7:0] exp_byte(input logic fm, input logic [3:0] en,
            input logic ln, input logic rx, input logic tm, input logic tx, input logic md);
        logic [2:0] id;
        logic       hit;
        hit = 1'b1;
        if (ln && en[2])            id = 3'b011;
        else if (rx && en[0])       id = 3'b010;
        else if (tm && en[0] && fm) id = 3'b110;
        else if (tx && en[1])       id = 3'b001;
        else if (md && en[3])       id = 3'b000;
        else begin id = 3'b000; hit = 1'b0; end
        return {fm, 3'b000, id, ~hit};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        chk("R1 reset byte", iir_byte, 8'h01);
        chk("R1 reset irq", {7'b0, irq}, 8'h00);

        // All four latched sources at once with everything masked.
        line_err_evt = 1'b1; rx_char_evt = 1'b1; tx_empty_evt = 1'b1; modem_in = 4'hA;
        step();
        {line_err_evt, rx_char_evt, tx_empty_evt} = '0;
        chk("R10 masked byte", iir_byte, 8'h01);
        chk("R11 masked irq", {7'b0, irq}, 8'h00);

        // Sweep every enable pattern with all sources pending.
        for (int e = 0; e < 16; e++) begin
            logic [7:0] x;
            ien = e[3:0];
            #1;
            x = exp_byte(1'b0, ien, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
            chk("R3 R10 enable sweep", iir_byte, x);
            chk("R11 irq sweep", {7'b0, irq}, {7'b0, ~x[0]});
        end

        // Priority walk as each source is serviced.
        ien = 4'hF;
        #1;
        chk("R3 line first", iir_byte, 8'h06);
        strobe(6);
        chk("R8 iir read leaves tx while line shown", iir_byte, 8'h06);
        strobe(3);
        chk("R4 R3 line cleared, rx next", iir_byte, 8'h04);
        strobe(4);
        chk("R5 R3 rx cleared, tx next", iir_byte, 8'h02);
        rd_iir = 1'b1;
        #1;
        chk("R12 byte during read", iir_byte, 8'h02);
        step();
        rd_iir = 1'b0;
        chk("R8 tx cleared by iir read, modem next", iir_byte, 8'h00);
        strobe(5);
        chk("R9 modem cleared", iir_byte, 8'h01);
        chk("R11 irq idle", {7'b0, irq}, 8'h00);

        // Transmitter empty cleared by a holding write.
        strobe(2);
        chk("R8 tx set", iir_byte, 8'h02);
        strobe(7);
        chk("R8 tx cleared by write", iir_byte, 8'h01);

        // A masked line event is kept.
        ien = 4'h0;
        strobe(0);
        chk("R10 masked line hidden", iir_byte, 8'h01);
        ien = 4'hF;
        #1;
        chk("R10 line reappears", iir_byte, 8'h06);
        strobe(3);
        chk("R4 line cleared", iir_byte, 8'h01);

        // Non-FIFO received data.
        strobe(1);
        chk("R5 rx set", iir_byte, 8'h04);
        strobe(4);
        chk("R5 rx cleared", iir_byte, 8'h01);

        // Each modem input alone.
        for (int b = 0; b < 4; b++) begin
            modem_in[b] = ~modem_in[b];
            step();
            chk("R9 modem change", iir_byte, 8'h00);
            strobe(5);
            chk("R9 modem read", iir_byte, 8'h01);
        end

        // FIFO mode level sweep.
        fifo_mode = 1'b1;
        #1;
        chk("R2 fifo idle byte", iir_byte, 8'h81);
        for (int l = 0; l < 10; l++) begin
            rx_level = l[LVL_W-1:0];
            #1;
            chk("R6 level vs trigger", iir_byte, (l >= 4) ? 8'h84 : 8'h81);
        end
        rx_level = '0;
        step();

        // Character timeout.
        idle_limit = 8'd5;
        rx_level = 5'd2;
        strobe(1);
        repeat (5) step();
        chk("R7 no timeout yet", iir_byte, 8'h81);
        step();
        chk("R7 timeout reported", iir_byte, 8'h8C);
        rx_level = 5'd5;
        #1;
        chk("R3 data ahead of timeout", iir_byte, 8'h84);
        rx_level = 5'd2;
        #1;
        chk("R3 timeout behind data", iir_byte, 8'h8C);
        strobe(4);
        chk("R7 timeout cleared by read", iir_byte, 8'h81);

        // No timeout outside FIFO mode.
        fifo_mode = 1'b0;
        repeat (10) step();
        chk("R7 no timeout non-fifo", iir_byte, 8'h01);
        chk("R2 non-fifo bit7", {7'b0, iir_byte[7]}, 8'h00);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule